// File: doc/BRIEF.md
# Low/Full-Speed Serial Bus Packet Receiver

This block turns a stream of already-recovered bus line samples into packet bytes. Each cycle in which `bit_vld` is high carries one bit time of the two data lines. Clock recovery is done elsewhere. The receiver waits for the idle J state and then for the synchronization pattern. After that it decodes the transition-based line code, strips the inserted stuff bits and packs the remaining bits into bytes, least significant bit first. It marks the first byte of every packet and reports the end of each packet, with an error flag when the packet was malformed.

End of packet is taken from the single-ended zero (SE0) condition. A hub can add one bit time of skew just ahead of the SE0. The receiver drops that lone bit quietly, even when it breaks the stuffing rule. Any other framing or stuffing fault ends the packet with the error flag. The receiver then ignores the lines until it sees idle J followed by a new sync pattern. CRC checking and packet-ID decoding belong to the next stage.

The parameter `LOW_SPEED` swaps which data line carries the J state, so the same receiver serves either signalling rate.

Top module: `usbfs_rx`

## Requirements
- R1: While `rst_n` is low, and after it is released, `byte_vld`, `byte_sop`, `pkt_end` and `pkt_err` are low. The receiver then needs an idle J sample before it will accept a sync pattern.
- R2: With the default polarity, J is dp=1/dm=0, K is dp=0/dm=1 and SE0 is dp=0/dm=0. A packet starts only after J followed by K J K J K J K K. A pattern that breaks off early produces no output at all.
- R3: Each data bit decodes as 1 when the line state equals the previous J/K sample and as 0 when it differs.
- R4: Bits are packed least significant bit first. In the cycle after the sample that completes 8 bits, `byte_vld` pulses with the byte on `byte_data`. `byte_sop` is high together with the first byte of a packet only.
- R5: A 0 that follows six consecutive 1s is removed from the data. The final 1 of the sync pattern counts toward that run.
- R6: A 1 that follows six consecutive 1s inside the packet body ends the packet with `pkt_end` and `pkt_err`. Later line activity is ignored until idle J and a new sync pattern have been seen.
- R7: A single bit received after the last whole byte and just before the SE0 is discarded without an error. This holds even when that bit is a seventh consecutive 1.
- R8: If 2 to 7 bits of an incomplete byte are pending when SE0 arrives, the packet ends with `pkt_err` and the partial byte is not delivered.
- R9: Two or more SE0 samples followed by a J sample end the packet with `pkt_end` high and `pkt_err` low.
- R10: A single SE0 followed by J or K, or an SE0 run followed by K, ends the packet with `pkt_end` and `pkt_err`.
- R11: Cycles with `bit_vld` low change no state. A packet sent with idle cycles between its bits decodes the same as one sent without them.
- R12: An SE1 sample (both lines high) inside a packet ends it with `pkt_end` and `pkt_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | High when dp/dm hold one bit-time sample |
| dp | input | 1 | Positive data line sample |
| dm | input | 1 | Negative data line sample |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Received byte, first bit in bit 0 |
| byte_sop | output | 1 | Marks the first byte of a packet |
| pkt_end | output | 1 | One-cycle strobe at the end of a packet |
| pkt_err | output | 1 | Packet was malformed; valid with `pkt_end` |

## Verification
The properties assume that `dp` and `dm` only carry meaning in cycles where `bit_vld` is high. They also assume that every output event traces back to such a sample, which is why a strobe is checked against `bit_vld` one cycle earlier. The stimulus therefore changes the lines only together with a raised `bit_vld`. It drives them half a clock away from the sampling edge and keeps them steady through idle cycles. Every packet is built by a behavioural line encoder that stuffs bits after runs of six 1s. The skew and violation cases deliberately skip the stuffing step or insert raw bits, so that each malformed case is produced on purpose and never by accident.

// File: rtl/usbfs_rx_pkg.sv
package usbfs_rx_pkg;

    // Logical line state, encoded as {J-side line, K-side line}
    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [2:0] {
        ST_WAITJ = 3'd0,
        ST_HUNT  = 3'd1,
        ST_BODY  = 3'd2,
        ST_VIOL  = 3'd3,
        ST_EOP1  = 3'd4,
        ST_EOP2  = 3'd5
    } rx_st_e;

endpackage

// File: rtl/usbfs_rx_line.sv
module usbfs_rx_line
    import usbfs_rx_pkg::*;
#(
    parameter bit LOW_SPEED = 1'b0
) (
    input  logic  dp,
    input  logic  dm,
    output line_e line
);

    // Low-speed idles with the negative line high, so J/K swap sides
    generate
        if (LOW_SPEED) begin : g_ls
            assign line = line_e'({dm, dp});
        end else begin : g_fs
            assign line = line_e'({dp, dm});
        end
    endgenerate

endmodule

// File: rtl/usbfs_rx_destuff.sv
module usbfs_rx_destuff
    import usbfs_rx_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_vld,
    input  line_e line,
    input  logic  load,
    output logic  dbit,
    output logic  stuff,
    output logic  viol
);

    localparam int OW = $clog2(STUFF_RUN + 1);
    localparam logic [OW-1:0] RUN_V = OW'(STUFF_RUN);

    typedef struct packed {
        line_e         prev;
        logic [OW-1:0] ones;
    } ds_s;

    ds_s  ds_q, ds_d;
    logic is_data;
    logic at_run;

    assign is_data = (line == LN_J) || (line == LN_K);
    assign dbit    = (line == ds_q.prev);
    assign at_run  = (ds_q.ones == RUN_V);
    assign stuff   = at_run && !dbit;
    assign viol    = at_run && dbit;

    always_comb begin
        ds_d = ds_q;
        if (bit_vld && is_data) begin
            ds_d.prev = line;
            if (load) begin
                // last sync bit is a 1 and opens the run
                ds_d.ones = OW'(1);
            end else if (!dbit) begin
                ds_d.ones = '0;
            end else if (!at_run) begin
                ds_d.ones = ds_q.ones + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_q <= '{prev: LN_J, ones: '0};
        end else begin
            ds_q <= ds_d;
        end
    end

endmodule

// File: rtl/usbfs_rx.sv
module usbfs_rx
    import usbfs_rx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 6,
    parameter bit LOW_SPEED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              dp,
    input  logic              dm,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_sop,
    output logic              pkt_end,
    output logic              pkt_err
);

    localparam int SYNC_LEN = 8;
    localparam int IDX_W    = $clog2(SYNC_LEN);
    localparam int NB_W     = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SYNC_LEN - 1);
    localparam logic [NB_W-1:0]  NB_LAST  = NB_W'(BYTE_W - 1);

    typedef struct packed {
        rx_st_e            st;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] sh;
        logic [NB_W-1:0]   nbits;
        logic              first;
        logic              bvld;
        logic [BYTE_W-1:0] bdata;
        logic              sop;
        logic              pend;
        logic              perr;
    } rx_s;

    rx_s   rx_q, rx_d;
    line_e line;
    line_e sync_exp;
    logic  dbit, stuff, viol;
    logic  load;
    logic  fail;

    usbfs_rx_line #(.LOW_SPEED(LOW_SPEED)) u_line (
        .dp   (dp),
        .dm   (dm),
        .line (line)
    );

    usbfs_rx_destuff #(.STUFF_RUN(STUFF_RUN)) u_destuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .line    (line),
        .load    (load),
        .dbit    (dbit),
        .stuff   (stuff),
        .viol    (viol)
    );

    // K on even positions and the last one, J on odd positions
    assign sync_exp = (rx_q.idx == IDX_LAST) ? LN_K :
                      (rx_q.idx[0] ? LN_J : LN_K);

    always_comb begin
        rx_d      = rx_q;
        rx_d.bvld = 1'b0;
        rx_d.sop  = 1'b0;
        rx_d.pend = 1'b0;
        rx_d.perr = 1'b0;
        load      = 1'b0;
        fail      = 1'b0;

        if (bit_vld) begin
            unique case (rx_q.st)
                ST_WAITJ: begin
                    if (line == LN_J) begin
                        rx_d.st  = ST_HUNT;
                        rx_d.idx = '0;
                    end
                end
                ST_HUNT: begin
                    if (line == sync_exp) begin
                        if (rx_q.idx == IDX_LAST) begin
                            rx_d.st    = ST_BODY;
                            rx_d.nbits = '0;
                            rx_d.first = 1'b1;
                            load       = 1'b1;
                        end else begin
                            rx_d.idx = rx_q.idx + 1'b1;
                        end
                    end else if (line == LN_J) begin
                        rx_d.idx = '0;
                    end else begin
                        rx_d.st = ST_WAITJ;
                    end
                end
                ST_BODY: begin
                    if (line == LN_SE0) begin
                        // zero or one pending bit: the lone bit is skew
                        if (rx_q.nbits <= NB_W'(1)) begin
                            rx_d.st = ST_EOP1;
                        end else begin
                            fail = 1'b1;
                        end
                    end else if (line == LN_SE1) begin
                        fail = 1'b1;
                    end else if (viol) begin
                        rx_d.st = ST_VIOL;
                    end else if (!stuff) begin
                        rx_d.sh = {dbit, rx_q.sh[BYTE_W-1:1]};
                        if (rx_q.nbits == NB_LAST) begin
                            rx_d.bvld  = 1'b1;
                            rx_d.bdata = {dbit, rx_q.sh[BYTE_W-1:1]};
                            rx_d.sop   = rx_q.first;
                            rx_d.first = 1'b0;
                            rx_d.nbits = '0;
                        end else begin
                            rx_d.nbits = rx_q.nbits + 1'b1;
                        end
                    end
                end
                ST_VIOL: begin
                    // tolerated only as a skew bit right after a whole byte
                    if (line == LN_SE0 && rx_q.nbits == '0) begin
                        rx_d.st = ST_EOP1;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_EOP1: begin
                    if (line == LN_SE0) begin
                        rx_d.st = ST_EOP2;
                    end else begin
                        fail = 1'b1;
                    end
                end
                ST_EOP2: begin
                    if (line == LN_J) begin
                        rx_d.pend = 1'b1;
                        rx_d.st   = ST_HUNT;
                        rx_d.idx  = '0;
                    end else if (line != LN_SE0) begin
                        fail = 1'b1;
                    end
                end
                default: begin
                    rx_d.st = ST_WAITJ;
                end
            endcase

            if (fail) begin
                rx_d.pend = 1'b1;
                rx_d.perr = 1'b1;
                rx_d.st   = ST_WAITJ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '{st: ST_WAITJ, default: '0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld  = rx_q.bvld;
    assign byte_data = rx_q.bdata;
    assign byte_sop  = rx_q.sop;
    assign pkt_end   = rx_q.pend;
    assign pkt_err   = rx_q.perr;

endmodule

// File: rtl/usbfs_rx_chk.sv
module usbfs_rx_chk #(
    parameter bit LOW_SPEED = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic dp,
    input logic dm,
    input logic byte_vld,
    input logic byte_sop,
    input logic pkt_end,
    input logic pkt_err
);

    logic j_now;
    assign j_now = LOW_SPEED ? (dm && !dp) : (dp && !dm);

    // R4: start marker only rides on a delivered byte
    a_r4_sop_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_sop |-> byte_vld);

    // R4: a byte strobe and a packet end never share a cycle
    a_r4_byte_end_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && pkt_end));

    // R6, R8, R10, R12: error flag only qualifies an end strobe
    a_r6_err_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_err |-> pkt_end);

    // R11: every output event follows a valid sample
    a_r11_event_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld || pkt_end) |-> $past(bit_vld));

    // R9: a clean end is always closed by a J sample
    a_r9_clean_end_on_j: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !pkt_err) |-> $past(bit_vld && j_now));

endmodule

bind usbfs_rx usbfs_rx_chk #(.LOW_SPEED(LOW_SPEED)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .dp       (dp),
    .dm       (dm),
    .byte_vld (byte_vld),
    .byte_sop (byte_sop),
    .pkt_end  (pkt_end),
    .pkt_err  (pkt_err)
);

// File: tb/usbfs_rx_test.sv
`timescale 1ns/1ps
module usbfs_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       dp = 1'b1;
    logic       dm = 1'b0;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_sop;
    logic       pkt_end;
    logic       pkt_err;

    always #10 clk = ~clk;

    usbfs_rx uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld   (bit_vld),
        .dp        (dp),
        .dm        (dm),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_sop  (byte_sop),
        .pkt_end   (pkt_end),
        .pkt_err   (pkt_err)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    gaps = 1'b0;
    int    gcnt = 0;
    bit    cur  = 1'b1;   // 1 = J, 0 = K
    int    ones = 0;
    bit    done = 1'b0;

    // event code: bit 10 end, bit 9 error, bit 8 sop, bits 7:0 data
    function automatic void exp_byte(bit [7:0] d, bit s, string t);
        exp_q.push_back((int'(s) << 8) | int'(d));
        tag_q.push_back(t);
    endfunction

    function automatic void exp_end(bit e, string t);
        exp_q.push_back((1 << 10) | (int'(e) << 9));
        tag_q.push_back(t);
    endfunction

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done && (byte_vld || pkt_end)) begin
            int act;
            act = byte_vld ? ((int'(byte_sop) << 8) | int'(byte_data))
                           : ((1 << 10) | (int'(pkt_err) << 9));
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2/R6 unexpected event: got %h expected none", act);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act != e) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", t, act, e);
                end
            end
        end
    end

    task automatic drive(bit p, bit m);
        dp = p;
        dm = m;
        bit_vld = 1'b1;
        @(negedge clk);
        if (gaps) begin
            gcnt++;
            if (gcnt % 2 == 0) begin
                bit_vld = 1'b0;
                @(negedge clk);
            end
        end
    endtask

    task automatic emit(bit j);
        drive(j, !j);
    endtask

    task automatic tog();
        cur = !cur;
        emit(cur);
    endtask

    task automatic dbit(bit b);
        if (ones == 6) begin
            tog();
            ones = 0;
        end
        if (b) begin
            emit(cur);
            ones++;
        end else begin
            tog();
            ones = 0;
        end
    endtask

    task automatic send_sync();
        emit(1'b1); emit(1'b1); emit(1'b1);
        emit(1'b0); emit(1'b1); emit(1'b0); emit(1'b1);
        emit(1'b0); emit(1'b1); emit(1'b0); emit(1'b0);
        cur  = 1'b0;
        ones = 1;
    endtask

    task automatic send_byte(bit [7:0] v);
        for (int i = 0; i < 8; i++) dbit(v[i]);
    endtask

    task automatic se0();
        drive(1'b0, 1'b0);
    endtask

    task automatic tail_j();
        cur = 1'b1;
        emit(1'b1);
        emit(1'b1);
    endtask

    task automatic eop();
        if (ones == 6) begin
            tog();
            ones = 0;
        end
        se0();
        se0();
        tail_j();
    endtask

    task automatic idle(int n);
        bit_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic close_scn(string t);
        idle(4);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: got %0d missing events expected 0", t, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        n_tests++;
        if (byte_vld || byte_sop || pkt_end || pkt_err) begin
            n_fail++;
            $display("FAIL R1 reset: got %b%b%b%b expected 0000",
                     byte_vld, byte_sop, pkt_end, pkt_err);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_tests++;
        if (byte_vld || byte_sop || pkt_end || pkt_err) begin
            n_fail++;
            $display("FAIL R1 after reset: got %b%b%b%b expected 0000",
                     byte_vld, byte_sop, pkt_end, pkt_err);
        end

        // R3, R4, R9: plain packet
        exp_byte(8'hA5, 1'b1, "R3/R4 first byte");
        exp_byte(8'h3C, 1'b0, "R4 second byte");
        exp_end(1'b0, "R9 clean end");
        send_sync(); send_byte(8'hA5); send_byte(8'h3C); eop();
        close_scn("R4 plain");

        // R5: stuffing, sync 1 counts toward the run
        exp_byte(8'hFF, 1'b1, "R5 stuffed 1");
        exp_byte(8'hFF, 1'b0, "R5 stuffed 2");
        exp_byte(8'h7F, 1'b0, "R5 stuffed 3");
        exp_end(1'b0, "R5 end");
        send_sync(); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h7F); eop();
        close_scn("R5 stuffing");

        // R7: ordinary skew bit
        exp_byte(8'h12, 1'b1, "R7 skew byte");
        exp_end(1'b0, "R7 skew end");
        send_sync(); send_byte(8'h12); tog(); se0(); se0(); tail_j();
        close_scn("R7 skew");

        // R7: skew bit that is a seventh 1
        exp_byte(8'hFC, 1'b1, "R7 viol-skew byte");
        exp_end(1'b0, "R7 viol-skew end");
        send_sync(); send_byte(8'hFC); emit(cur); se0(); se0(); tail_j();
        close_scn("R7 viol-skew");

        // R6: stuff violation mid packet, rest ignored
        exp_byte(8'hFC, 1'b1, "R6 byte before violation");
        exp_end(1'b1, "R6 stuff error");
        send_sync(); send_byte(8'hFC); emit(cur); ones = 0;
        send_byte(8'h55); eop();
        close_scn("R6 violation");

        // R8: partial byte at SE0
        exp_byte(8'h5A, 1'b1, "R8 whole byte");
        exp_end(1'b1, "R8 partial error");
        send_sync(); send_byte(8'h5A); dbit(1'b1); dbit(1'b0); dbit(1'b1); eop();
        close_scn("R8 partial");

        // R10: single SE0
        exp_byte(8'h33, 1'b1, "R10 byte a");
        exp_end(1'b1, "R10 single SE0");
        send_sync(); send_byte(8'h33); se0(); tail_j();
        close_scn("R10 single");

        // R10: K after SE0 run
        exp_byte(8'h44, 1'b1, "R10 byte b");
        exp_end(1'b1, "R10 K after SE0");
        send_sync(); send_byte(8'h44); se0(); se0(); cur = 1'b0; emit(1'b0); tail_j();
        close_scn("R10 K end");

        // R2: broken sync gives nothing, next packet accepted
        exp_byte(8'h81, 1'b1, "R2 byte after broken sync");
        exp_end(1'b0, "R2 end");
        emit(1'b1); emit(1'b1); emit(1'b0); emit(1'b1); emit(1'b0); emit(1'b0);
        send_sync(); send_byte(8'h81); eop();
        close_scn("R2 sync");

        // R11: idle cycles between bits
        exp_byte(8'hC3, 1'b1, "R11 gap byte 1");
        exp_byte(8'h0F, 1'b0, "R11 gap byte 2");
        exp_end(1'b0, "R11 gap end");
        gaps = 1'b1;
        send_sync(); send_byte(8'hC3); send_byte(8'h0F); eop();
        gaps = 1'b0;
        close_scn("R11 gaps");

        // R12: SE1 inside packet
        exp_byte(8'h77, 1'b1, "R12 byte");
        exp_end(1'b1, "R12 SE1 error");
        send_sync(); send_byte(8'h77); drive(1'b1, 1'b1); eop();
        close_scn("R12 SE1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule